// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt request lines and turns each one into a clean, per-line interrupt for a parent interrupt controller. Every line is first brought into the block clock domain. It is then checked against the sense mode that software chose for it: active-low level, active-high level, falling edge, rising edge, or either edge. When the chosen condition is seen, the line's detect bit latches. Software clears a detect bit by writing a one to it.

A per-line enable mask gates the detect bits onto the interrupt outputs. The mask is changed through two separate write paths, one that sets bits and one that clears them, so no read-modify-write is needed. Software uses a single-cycle register bus with combinational read data. Through it, software programs the sense modes, services detect bits, reads the pending requests and samples the raw line levels.

Top module: `extirq_sense_ctrl`

## Requirements
- R1: Line n occupies bit n of every status, enable and monitor register. Its configuration word sits at byte offset 0x180 + 4*n, and bits [5:0] of that word form the sense-select field.
- R2: Sense code 0x01 selects active-low level and 0x02 selects active-high level. While the selected level is present on the synchronized input, the line's detect bit sets.
- R3: Sense code 0x04 selects falling edge, 0x08 rising edge and 0x0C both edges. An edge is found by comparing the synchronized sample with the sample one block clock earlier.
- R4: Any other sense code, including 0x00, detects nothing. Configuration bits 31:6 read back as written and have no effect on detection.
- R5: The detect status register at 0x100 is write-one-to-clear, and written zeros leave bits unchanged. When a clear and a new detection meet in one cycle, the clear wins. In a level mode, the bit sets again one cycle later if the level is still active.
- R6: Writing ones to offset 0x08 sets the matching enable bits and leaves the other enable bits as they were. Reading 0x08 returns zero.
- R7: Writing ones to offset 0x04 clears the matching enable bits. Reading 0x04 returns the current enable mask.
- R8: Output bit n of irqOut is a register that holds (detect n AND enable n) from the previous cycle. Offset 0x00 reads back the irqOut vector.
- R9: Offset 0x104 returns the synchronized level of every input line. The synchronizer is two flops deep.
- R10: After reset, all detect bits, enable bits, configuration words and outputs read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| lineIn | input | NUM_LINES | External interrupt request lines |
| irqOut | output | NUM_LINES | Per-line interrupt to the parent controller |

## Verification
On every cycle, the assertions check the enable set and clear paths, the clear-wins rule of the detect register, and the fact that no detect bit drops without a clear. They also check that each output follows the previous cycle's detect-and-enable product and that the request register mirrors the outputs. Whether the right condition is detected for each sense code, including the invalid codes and the ignored high configuration bits, can only be shown by the bench's driven waveforms. The same holds for the re-detection after a clear while a level is still active, and for the placement of the configuration word of a line other than line zero.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int MAX_LINES = 32;
  localparam int DW        = 32;

  localparam logic [5:0] SENSE_LOW  = 6'h01;
  localparam logic [5:0] SENSE_HIGH = 6'h02;
  localparam logic [5:0] SENSE_FALL = 6'h04;
  localparam logic [5:0] SENSE_RISE = 6'h08;
  localparam logic [5:0] SENSE_BOTH = 6'h0C;

  localparam logic [11:0] OFS_REQ  = 12'h000;
  localparam logic [11:0] OFS_ENCL = 12'h004;
  localparam logic [11:0] OFS_ENST = 12'h008;
  localparam logic [11:0] OFS_DET  = 12'h100;
  localparam logic [11:0] OFS_MON  = 12'h104;

  typedef struct packed {
    logic [DW-1:0] enSet;
    logic [DW-1:0] enClr;
    logic [DW-1:0] detClr;
    logic          cfgWr;
    logic [4:0]    cfgIdx;
    logic [DW-1:0] cfgData;
  } busStrobeT;
endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [11:0]          busAddr,
  input  logic [DW-1:0]        busWdata,
  input  logic [NUM_LINES-1:0] detVec,
  input  logic [NUM_LINES-1:0] enVec,
  input  logic [NUM_LINES-1:0] monVec,
  input  logic [NUM_LINES-1:0] irqVec,
  input  logic [DW-1:0]        cfgRdData,
  output logic [4:0]           cfgRdIdx,
  output busStrobeT            strobes,
  output logic [DW-1:0]        busRdata
);
  logic wrEn;
  logic inCfgWin;
  logic cfgHit;
  logic [DW-1:0] detPad, enPad, monPad, irqPad;

  assign wrEn     = busSel && busWr;
  assign inCfgWin = (busAddr[11:7] == 5'b00011) && (busAddr[1:0] == 2'b00);
  assign cfgRdIdx = busAddr[6:2];
  assign cfgHit   = inCfgWin && (int'(busAddr[6:2]) < NUM_LINES);

  always_comb begin
    strobes         = '0;
    strobes.cfgIdx  = busAddr[6:2];
    strobes.cfgData = busWdata;
    if (wrEn) begin
      strobes.enSet  = (busAddr == OFS_ENST) ? busWdata : '0;
      strobes.enClr  = (busAddr == OFS_ENCL) ? busWdata : '0;
      strobes.detClr = (busAddr == OFS_DET)  ? busWdata : '0;
      strobes.cfgWr  = cfgHit;
    end
  end

  always_comb begin
    detPad = '0; enPad = '0; monPad = '0; irqPad = '0;
    detPad[NUM_LINES-1:0] = detVec;
    enPad[NUM_LINES-1:0]  = enVec;
    monPad[NUM_LINES-1:0] = monVec;
    irqPad[NUM_LINES-1:0] = irqVec;
  end

  always_comb begin
    busRdata = '0;
    if (cfgHit) busRdata = cfgRdData;
    else begin
      case (busAddr)
        OFS_REQ:  busRdata = irqPad;
        OFS_ENCL: busRdata = enPad;
        OFS_DET:  busRdata = detPad;
        OFS_MON:  busRdata = monPad;
        default:  busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobeT            strobes,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [4:0]           cfgRdIdx,
  output logic [DW-1:0]        cfgRdData,
  output logic [NUM_LINES-1:0] detVec,
  output logic [NUM_LINES-1:0] enVec,
  output logic [NUM_LINES-1:0] monVec,
  output logic [NUM_LINES-1:0] irqVec
);
  logic [NUM_LINES-1:0] syncA, syncB, prevB, hitVec;
  logic [DW-1:0]        cfgReg [NUM_LINES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end
  assign monVec = syncB;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [5:0] sense;
    logic       rise, fall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgReg[g] <= '0;
      else if (strobes.cfgWr && (int'(strobes.cfgIdx) == g)) cfgReg[g] <= strobes.cfgData;
    end

    assign sense = cfgReg[g][5:0];
    assign rise  = syncB[g] && !prevB[g];
    assign fall  = !syncB[g] && prevB[g];

    always_comb begin
      case (sense)
        SENSE_LOW:  hitVec[g] = !syncB[g];
        SENSE_HIGH: hitVec[g] = syncB[g];
        SENSE_FALL: hitVec[g] = fall;
        SENSE_RISE: hitVec[g] = rise;
        SENSE_BOTH: hitVec[g] = rise || fall;
        default:    hitVec[g] = 1'b0;
      endcase
    end
  end

  assign cfgRdData = (int'(cfgRdIdx) < NUM_LINES) ? cfgReg[cfgRdIdx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detVec <= '0;
      enVec  <= '0;
      irqVec <= '0;
    end else begin
      detVec <= (detVec | hitVec) & ~strobes.detClr[NUM_LINES-1:0];
      enVec  <= (enVec | strobes.enSet[NUM_LINES-1:0]) & ~strobes.enClr[NUM_LINES-1:0];
      irqVec <= detVec & enVec;
    end
  end
endmodule

// File: rtl/extirq_sense_ctrl.sv
module extirq_sense_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [11:0]          busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [NUM_LINES-1:0] irqOut
);
  busStrobeT            strobes;
  logic [NUM_LINES-1:0] detVec, enVec, monVec;
  logic [DW-1:0]        cfgRdData;
  logic [4:0]           cfgRdIdx;

  extirq_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .detVec(detVec), .enVec(enVec), .monVec(monVec), .irqVec(irqOut),
    .cfgRdData(cfgRdData), .cfgRdIdx(cfgRdIdx), .strobes(strobes),
    .busRdata(busRdata)
  );

  extirq_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lineIn(lineIn),
    .cfgRdIdx(cfgRdIdx), .cfgRdData(cfgRdData),
    .detVec(detVec), .enVec(enVec), .monVec(monVec), .irqVec(irqOut)
  );
endmodule

// File: rtl/extirq_sense_chk.sv
module extirq_sense_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWr,
  input logic [11:0]          busAddr,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic [NUM_LINES-1:0] irqOut,
  input logic [NUM_LINES-1:0] detVec,
  input logic [NUM_LINES-1:0] enVec
);
  logic [NUM_LINES-1:0] wMask, clrMask;
  logic wEnSet, wEnClr, wDet, rdReq;

  assign wMask   = busWdata[NUM_LINES-1:0];
  assign wEnSet  = busSel && busWr && (busAddr == 12'h008);
  assign wEnClr  = busSel && busWr && (busAddr == 12'h004);
  assign wDet    = busSel && busWr && (busAddr == 12'h100);
  assign rdReq   = busSel && !busWr && (busAddr == 12'h000);
  assign clrMask = wDet ? wMask : '0;

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    wEnSet |=> ((enVec & $past(wMask)) == $past(wMask)));                   // R6
  AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wEnClr |=> ((enVec & $past(wMask)) == '0));                             // R7
  AST_DETECT_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wDet |=> ((detVec & $past(wMask)) == '0));                              // R5
  AST_DETECT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(detVec) & ~$past(clrMask) & ~detVec) == '0));          // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(detVec & enVec)));                            // R8
  AST_REQ_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (busRdata[NUM_LINES-1:0] == irqOut));                         // R8
endmodule

bind extirq_sense_ctrl extirq_sense_chk #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/extirq_sense_ctrl_bench.sv
module extirq_sense_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int NVEC = 13;

  // each entry: {config word [11:0], initial level, final level, expected detect}
  localparam logic [14:0] VEC [NVEC] = '{
    {12'h001, 1'b1, 1'b0, 1'b1},  // R2 low level
    {12'h001, 1'b1, 1'b1, 1'b0},  // R2 low level, never low
    {12'h002, 1'b0, 1'b1, 1'b1},  // R2 high level
    {12'h002, 1'b0, 1'b0, 1'b0},  // R2 high level, never high
    {12'h004, 1'b1, 1'b0, 1'b1},  // R3 falling
    {12'h004, 1'b0, 1'b1, 1'b0},  // R3 falling, rising given
    {12'h008, 1'b0, 1'b1, 1'b1},  // R3 rising
    {12'h008, 1'b1, 1'b0, 1'b0},  // R3 rising, falling given
    {12'h00C, 1'b0, 1'b1, 1'b1},  // R3 both, rise
    {12'h00C, 1'b1, 1'b0, 1'b1},  // R3 both, fall
    {12'h000, 1'b0, 1'b1, 1'b0},  // R4 zero code
    {12'h003, 1'b0, 1'b1, 1'b0},  // R4 invalid code
    {12'hF48, 1'b0, 1'b1, 1'b1}   // R4 high bits ignored, rising
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NL-1:0] lineIn = '0, irqOut;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  extirq_sense_ctrl #(.NUM_LINES(NL)) u_extirq_sense_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .lineIn(lineIn), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R10 reset state
    rdReg(12'h100, r); check("R10 detect", r, 32'h0);
    rdReg(12'h004, r); check("R10 enable", r, 32'h0);
    rdReg(12'h000, r); check("R10 request", r, 32'h0);
    rdReg(12'h180, r); check("R10 config", r, 32'h0);
    check("R10 irqOut", irqOut, 32'h0);

    // table of sense modes on line 0
    for (int v = 0; v < NVEC; v++) begin
      wrReg(12'h180, 32'h0);
      lineIn[0] = VEC[v][2];
      idle(6);
      wrReg(12'h180, {20'h0, VEC[v][14:3]});
      idle(6);
      wrReg(12'h100, 32'hFFFF_FFFF);
      lineIn[0] = VEC[v][1];
      idle(6);
      rdReg(12'h100, r);
      check($sformatf("R2/R3/R4 vector %0d", v), {31'h0, r[0]}, {31'h0, VEC[v][0]});
    end
    rdReg(12'h180, r); check("R4 high bits read back", r, 32'h0000_0F48);

    // R1 line 5 config at 0x194, rising edge, only bit 5 detects
    wrReg(12'h180, 32'h0);
    lineIn = '0; idle(6);
    wrReg(12'h100, 32'hFFFF_FFFF);
    wrReg(12'h194, 32'h8);
    lineIn = 32'h0000_0021;
    idle(6);
    rdReg(12'h100, r); check("R1 line 5 mapping", r, 32'h0000_0020);

    // R9 monitor shows synchronized levels
    rdReg(12'h104, r); check("R9 monitor", r, 32'h0000_0021);
    lineIn = 32'h8000_0000;
    @(negedge clk);
    rdReg(12'h104, r); check("R9 not yet through sync", r, 32'h0000_0021);
    @(negedge clk);
    rdReg(12'h104, r); check("R9 after two flops", r, 32'h8000_0000);

    // R5 write zero leaves bit, write one clears
    wrReg(12'h100, 32'h0);
    rdReg(12'h100, r); check("R5 zero write keeps", r, 32'h0000_0020);
    wrReg(12'h100, 32'h0000_0020);
    rdReg(12'h100, r); check("R5 one write clears", r, 32'h0);

    // R5 level re-sets one cycle after clear
    wrReg(12'h188, 32'h2);
    lineIn[2] = 1'b1;
    idle(5);
    rdReg(12'h100, r); check("R2 level high line 2", r, 32'h0000_0004);
    wrReg(12'h100, 32'h0000_0004);
    rdReg(12'h100, r); check("R5 cleared", r, 32'h0);
    @(negedge clk);
    rdReg(12'h100, r); check("R5 level re-set", r, 32'h0000_0004);

    // R6/R7 enable paths
    wrReg(12'h008, 32'h0000_0005);
    rdReg(12'h004, r); check("R6 set", r, 32'h0000_0005);
    rdReg(12'h008, r); check("R6 set reads zero", r, 32'h0);
    wrReg(12'h008, 32'h0000_0010);
    rdReg(12'h004, r); check("R6 set keeps others", r, 32'h0000_0015);
    wrReg(12'h004, 32'h0000_0001);
    rdReg(12'h004, r); check("R7 clear", r, 32'h0000_0014);

    // R8 output = registered detect AND enable; line 2 detected and enabled
    rdReg(12'h000, r); check("R8 request", r, 32'h0000_0004);
    check("R8 irqOut", irqOut, 32'h0000_0004);
    wrReg(12'h004, 32'h0000_0004);
    check("R8 irq one cycle behind", irqOut, 32'h0000_0004);
    @(negedge clk);
    check("R8 irq drops", irqOut, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule